// File: doc/BRIEF.md
# Pixel Clock Output Select and Gating

This block sits between the clock core of a line-locked pixel clock generator and its output pads. It chooses what appears on a single status pin. The choices are PLL lock, phase-adjust lock, their combination, the conditioned horizontal sync corrected for its polarity bit, or the divided local oscillator reference. The choice is made jointly by two lock-report enables and an input-select bit.

It re-times a horizontal sync onto the pixel clock for a function pin. That sync is either the loop-recovered one or the conditioned input, and a synchroniser chain does the re-timing. The block also produces a single-ended pixel clock with its own power-of-two scaler and a half-rate clock with optional inversion.

Every pad-bound signal except the status pin has a drive-enable. When that enable is off, the output is held low and its pad enable is deasserted, so the pad floats. Control bits come from a register bank elsewhere. A PLL reset pulse from that bank re-phases the half-rate clock and the scaler.

Top module: `vid_out_sel`

## Requirements
- R1: While `rst_n` is low, all five pad enables (`*_oe`) are 0, `func_out` is 0 and the half-rate toggle is 0 (both half-clock pins show `half_inv` gated by their enables).
- R2: With `lock_en_pll`=0 and `lock_en_dpa`=0, `stat_out` equals `sync_in` XOR `ref_pol` when `in_sel`=0, and equals `osc_ref` when `in_sel`=1.
- R3: With `lock_en_pll`=1 and `lock_en_dpa`=0, `stat_out` equals `pll_lock` whatever `in_sel` is.
- R4: With `lock_en_pll`=0 and `lock_en_dpa`=1, `stat_out` equals `dpa_lock` whatever `in_sel` is.
- R5: With both lock enables at 1, `stat_out` equals `pll_lock` AND `dpa_lock`.
- R6: `func_sel`=0 routes `sync_rec` and `func_sel`=1 routes `sync_in` to `func_out`. A change at the input is seen at `func_out` after exactly SYNC_STAGES (default 2) rising pixel-clock edges.
- R7: `scl_code` values 0, 1, 2 and 3 give `pclk_se` equal to the pixel clock, and to it divided by 2, 4 and 8 respectively. For a code c>0, the output after the k-th edge since restart is bit c-1 of k.
- R8: A change of `scl_code`, or a `pll_rst` pulse, restarts the scaler counter at 0 on the next rising edge. The new code takes effect on that same edge.
- R9: The half-rate toggle inverts on every rising edge without `pll_rst`. `hclk_se` and `hclk_diff` equal the toggle XOR `half_inv`.
- R10: A rising edge with `pll_rst`=1 forces the half-rate toggle to 0.
- R11: Enable bit `oe` positions are [0] differential clock, [1] single-ended clock, [2] differential half clock, [3] single-ended half clock and [4] function. A 0 bit drives the matching `_oe` output to 0 and holds the data output at 0. A 1 bit passes the data and raises `_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_rst | input | 1 | PLL reset pulse, re-phases half clock and scaler |
| lock_en_pll | input | 1 | Report PLL lock on status pin |
| lock_en_dpa | input | 1 | Report phase-adjust lock on status pin |
| in_sel | input | 1 | Loop input select: 0 sync, 1 oscillator |
| ref_pol | input | 1 | Reference polarity bit |
| func_sel | input | 1 | Function pin source: 0 recovered, 1 input sync |
| pll_lock | input | 1 | PLL lock flag |
| dpa_lock | input | 1 | Phase-adjust lock flag |
| sync_in | input | 1 | Conditioned horizontal sync input |
| sync_rec | input | 1 | Recovered horizontal sync from loop divider |
| osc_ref | input | 1 | Divided oscillator reference |
| scl_code | input | SCL_W | Single-ended clock scaler code |
| half_inv | input | 1 | Half-rate clock inversion |
| oe | input | 5 | Per-output enables |
| stat_out | output | 1 | Status pin value |
| pclk_diff | output | 1 | Differential pixel clock data |
| pclk_diff_oe | output | 1 | Differential pixel clock pad enable |
| pclk_se | output | 1 | Scaled single-ended pixel clock |
| pclk_se_oe | output | 1 | Single-ended pixel clock pad enable |
| hclk_diff | output | 1 | Differential half-rate clock data |
| hclk_diff_oe | output | 1 | Differential half-rate pad enable |
| hclk_se | output | 1 | Single-ended half-rate clock |
| hclk_se_oe | output | 1 | Single-ended half-rate pad enable |
| func_out | output | 1 | Re-timed sync for function pin |
| func_oe | output | 1 | Function pad enable |

## Verification
The bench builds the block with SCL_W=2 and SYNC_STAGES=2, the default values. A two-bit scaler code reaches every divide ratio up to 8, so sixteen edges per code cover two full wraps of the largest divide. The bench also switches between codes in mid-count, so a counter that fails to restart shows up in the next sample. A two-stage synchroniser makes the function-pin latency short enough to check at both the edge before the new value arrives and the edge on which it arrives.

// File: rtl/vid_out_sel.sv
module vid_out_sel #(
  parameter int SCL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_rst,
  input  logic             lock_en_pll,
  input  logic             lock_en_dpa,
  input  logic             in_sel,
  input  logic             ref_pol,
  input  logic             func_sel,
  input  logic             pll_lock,
  input  logic             dpa_lock,
  input  logic             sync_in,
  input  logic             sync_rec,
  input  logic             osc_ref,
  input  logic [SCL_W-1:0] scl_code,
  input  logic             half_inv,
  input  logic [4:0]       oe,
  output logic             stat_out,
  output logic             pclk_diff,
  output logic             pclk_diff_oe,
  output logic             pclk_se,
  output logic             pclk_se_oe,
  output logic             hclk_diff,
  output logic             hclk_diff_oe,
  output logic             hclk_se,
  output logic             hclk_se_oe,
  output logic             func_out,
  output logic             func_oe
);
  localparam int CNT_W = (1 << SCL_W) - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt;
  logic [SCL_W-1:0]       scl_q;
  logic                   hq;
  logic                   div_bit;
  logic [4:0]             en;

  always_comb begin
    unique case ({lock_en_dpa, lock_en_pll})
      2'b00:   stat_out = in_sel ? osc_ref : (sync_in ^ ref_pol);
      2'b01:   stat_out = pll_lock;
      2'b10:   stat_out = dpa_lock;
      default: stat_out = pll_lock & dpa_lock;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], func_sel ? sync_in : sync_rec};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pll_rst) hq <= 1'b0;
    else                   hq <= ~hq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      scl_q <= '0;
    end else begin
      scl_q <= scl_code;
      if (pll_rst || scl_code != scl_q) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    div_bit = clk;
    for (int i = 1; i <= CNT_W; i++)
      if (int'(scl_q) == i) div_bit = cnt[i-1];
  end

  assign en           = rst_n ? oe : 5'b0;
  assign pclk_diff_oe = en[0];
  assign pclk_se_oe   = en[1];
  assign hclk_diff_oe = en[2];
  assign hclk_se_oe   = en[3];
  assign func_oe      = en[4];

  assign pclk_diff = en[0] & clk;
  assign pclk_se   = en[1] & div_bit;
  assign hclk_diff = en[2] & (hq ^ half_inv);
  assign hclk_se   = en[3] & (hq ^ half_inv);
  assign func_out  = en[4] & sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/vid_out_sel_chk.sv
module vid_out_sel_chk #(
  parameter int SCL_W = 2,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pll_rst,
  input logic             lock_en_pll,
  input logic             lock_en_dpa,
  input logic             pll_lock,
  input logic             dpa_lock,
  input logic             stat_out,
  input logic [SCL_W-1:0] scl_code,
  input logic [CNT_W-1:0] cnt,
  input logic             hq,
  input logic             pclk_se_oe,
  input logic             pclk_se,
  input logic             func_oe,
  input logic             func_out
);
  a_r3_pll_route: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en_pll && !lock_en_dpa) |-> stat_out == pll_lock);

  a_r4_dpa_route: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_en_pll && lock_en_dpa) |-> stat_out == dpa_lock);

  a_r8_scale_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && scl_code != $past(scl_code)) |=> cnt == '0);

  a_r9_half_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_rst |=> hq != $past(hq));

  a_r10_half_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |=> !hq);

  a_r11_se_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !pclk_se_oe |-> !pclk_se);

  a_r11_func_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !func_oe |-> !func_out);
endmodule

bind vid_out_sel vid_out_sel_chk #(.SCL_W(SCL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_rst(pll_rst),
  .lock_en_pll(lock_en_pll), .lock_en_dpa(lock_en_dpa),
  .pll_lock(pll_lock), .dpa_lock(dpa_lock), .stat_out(stat_out),
  .scl_code(scl_code), .cnt(cnt), .hq(hq),
  .pclk_se_oe(pclk_se_oe), .pclk_se(pclk_se),
  .func_oe(func_oe), .func_out(func_out)
);

// File: tb/sim_vid_out_sel.sv
module sim_vid_out_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0, pll_rst = 1'b0;
  logic lock_en_pll = 1'b0, lock_en_dpa = 1'b0, in_sel = 1'b0, ref_pol = 1'b0;
  logic func_sel = 1'b0, pll_lock = 1'b0, dpa_lock = 1'b0;
  logic sync_in = 1'b0, sync_rec = 1'b0, osc_ref = 1'b0, half_inv = 1'b0;
  logic [1:0] scl_code = 2'd0;
  logic [4:0] oe = 5'b0;
  logic stat_out, pclk_diff, pclk_diff_oe, pclk_se, pclk_se_oe;
  logic hclk_diff, hclk_diff_oe, hclk_se, hclk_se_oe, func_out, func_oe;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  vid_out_sel #(.SCL_W(2), .SYNC_STAGES(2)) u0 (.*);

  task automatic chk(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic after_pos();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; oe = 5'h1f; half_inv = 1'b0;
    repeat (3) after_pos();
    chk(pclk_diff_oe, 1'b0, "R1 pclk_diff_oe");
    chk(pclk_se_oe,   1'b0, "R1 pclk_se_oe");
    chk(hclk_diff_oe, 1'b0, "R1 hclk_diff_oe");
    chk(hclk_se_oe,   1'b0, "R1 hclk_se_oe");
    chk(func_oe,      1'b0, "R1 func_oe");
    chk(func_out,     1'b0, "R1 func_out");
    @(negedge clk); rst_n = 1'b1; oe = 5'b0;
  endtask

  task automatic t_status();
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      {lock_en_pll, lock_en_dpa, in_sel, ref_pol, sync_in} = 5'(v);
      osc_ref = v[1]; pll_lock = v[2] ^ v[0]; dpa_lock = v[1] ^ v[4];
      #1;
      if (!lock_en_pll && !lock_en_dpa)
        chk(stat_out, in_sel ? osc_ref : (sync_in ^ ref_pol), "R2 status sync/osc");
      else if (lock_en_pll && !lock_en_dpa)
        chk(stat_out, pll_lock, "R3 status pll lock");
      else if (!lock_en_pll && lock_en_dpa)
        chk(stat_out, dpa_lock, "R4 status dpa lock");
      else
        chk(stat_out, pll_lock & dpa_lock, "R5 status both locks");
    end
  endtask

  task automatic t_func();
    @(negedge clk); oe = 5'b10000; func_sel = 1'b0; sync_rec = 1'b1; sync_in = 1'b0;
    repeat (3) after_pos();
    chk(func_out, 1'b1, "R6 recovered high");
    @(negedge clk); sync_rec = 1'b0;
    after_pos(); chk(func_out, 1'b1, "R6 one edge still old");
    after_pos(); chk(func_out, 1'b0, "R6 two edges new");
    @(negedge clk); func_sel = 1'b1; sync_in = 1'b1;
    after_pos(); chk(func_out, 1'b0, "R6 input one edge");
    after_pos(); chk(func_out, 1'b1, "R6 input two edges");
    @(negedge clk); oe = 5'b0; #1;
    chk(func_out, 1'b0, "R11 func gated");
    chk(func_oe,  1'b0, "R11 func_oe low");
  endtask

  task automatic t_half();
    @(negedge clk); oe = 5'b01100; half_inv = 1'b0; pll_rst = 1'b1;
    after_pos(); chk(hclk_se, 1'b0, "R10 cleared");
    @(negedge clk); pll_rst = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      after_pos();
      chk(hclk_se,   1'(k & 1), "R9 toggle se");
      chk(hclk_diff, 1'(k & 1), "R9 toggle diff");
    end
    @(negedge clk); pll_rst = 1'b1;
    after_pos(); chk(hclk_se, 1'b0, "R10 clear from high");
    @(negedge clk); pll_rst = 1'b0; half_inv = 1'b1; #1;
    chk(hclk_se,   1'b1, "R9 inverted se");
    chk(hclk_diff, 1'b1, "R9 inverted diff");
    after_pos(); chk(hclk_se, 1'b0, "R9 inverted toggle");
    @(negedge clk); half_inv = 1'b0; oe = 5'b0;
  endtask

  task automatic t_scaler();
    int codes[4] = '{1, 2, 3, 0};
    @(negedge clk); oe = 5'b00010;
    foreach (codes[j]) begin
      @(negedge clk); scl_code = 2'(codes[j]);
      for (int k = 0; k < 16; k++) begin
        after_pos();
        if (codes[j] == 0) begin
          chk(pclk_se, 1'b1, "R7 div1 high");
          @(negedge clk); #1; chk(pclk_se, 1'b0, "R7 div1 low");
        end else
          chk(pclk_se, 1'((k >> (codes[j] - 1)) & 1), "R7/R8 divided clock");
      end
    end
    @(negedge clk); scl_code = 2'd3;
    repeat (5) after_pos();
    chk(pclk_se, 1'b1, "R7 div8 high at k4");
    @(negedge clk); pll_rst = 1'b1;
    after_pos(); chk(pclk_se, 1'b0, "R8 pll_rst restart");
    @(negedge clk); pll_rst = 1'b0;
    for (int k = 1; k < 9; k++) begin
      after_pos(); chk(pclk_se, 1'((k >> 2) & 1), "R8 after pll_rst");
    end
    @(negedge clk); oe = 5'b0;
  endtask

  task automatic t_enables();
    @(negedge clk); scl_code = 2'd0; half_inv = 1'b1; func_sel = 1'b1; sync_in = 1'b1;
    for (int b = -1; b < 5; b++) begin
      @(negedge clk); oe = (b < 0) ? 5'b0 : 5'(1 << b);
      repeat (3) after_pos();
      chk(pclk_diff_oe, oe[0], "R11 oe0");
      chk(pclk_se_oe,   oe[1], "R11 oe1");
      chk(hclk_diff_oe, oe[2], "R11 oe2");
      chk(hclk_se_oe,   oe[3], "R11 oe3");
      chk(func_oe,      oe[4], "R11 oe4");
      chk(pclk_diff, oe[0], "R11 pclk_diff data");
      chk(pclk_se,   oe[1], "R11 pclk_se data");
      chk(func_out,  oe[4], "R11 func data");
      if (b < 0) begin
        chk(hclk_diff, 1'b0, "R11 hclk_diff gated");
        chk(hclk_se,   1'b0, "R11 hclk_se gated");
      end
    end
  endtask

  initial begin
    t_reset();
    t_status();
    t_func();
    t_half();
    t_scaler();
    t_enables();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule